// File: doc/BRIEF.md
# Phase/Frequency Detector with Charge-Pump Mode Control

This block compares a strobe from the reference divider with a strobe from the feedback divider and drives the control pins of a three-state charge pump. The pins are a pump-up drive, a pump-down drive and an output enable; with the enable low the pump pin is modelled as high impedance. Both strobes are single-cycle pulses, synchronous to the block clock. The detector holds two flags. Each flag is set by its own strobe, and both are cleared together once both have been set for a programmable number of cycles. The flags therefore measure which strobe leads, over a range of up to a full period either way. When the loop is locked, the only output is a pair of minimum-width pulses.

Static configuration inputs control the pump pins:
- A polarity input swaps the meaning of up and down.
- A three-state input forces the pump off.
- A test input, set together with the three-state input, routes one divider strobe straight onto the pump pins.
- A counter-reset input holds the dividers at their load point.
- A power-down input, and a chip-enable pin, shut the loop down. The shutdown is either immediate, or deferred until the pump pulse in progress has finished.

A divider-hold output tells the neighbouring dividers to stay at their load point.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: With `rst_n` low, and in the first cycle after release with a normal configuration, `pump_up` and `pump_dn` are 0, `pump_oe` is 1, `pwr_down` is 0 and `div_hold` is 0.
- R2: A `ref_pulse` sets the lead flag in the next cycle, and a `fb_pulse` sets the lag flag. A flag stays set across further strobes on its own side until the other side's strobe arrives, which gives a detection range of ±2π.
- R3: Once both flags are set, they stay set for exactly `RST_DLY` cycles and are then cleared together. Simultaneous strobes therefore give up and down pulses `RST_DLY` cycles wide.
- R4: With `cfg_pol_pos`=1, `pump_up` follows the reference-side flag and `pump_dn` follows the feedback-side flag. With `cfg_pol_pos`=0, the two are swapped.
- R5: With `cfg_tri`=1 and `cfg_test`=0, `pump_oe`, `pump_up` and `pump_dn` are 0 and both flags are held clear. A strobe seen in this mode leaves no pulse afterwards.
- R6: With `cfg_test`=1 and `cfg_tri`=1, and the block not powered down, `pump_oe` is 1. `pump_up` equals the selected strobe in the same cycle and `pump_dn` is its complement. `cfg_pol_pos`=0 selects `ref_pulse`; `cfg_pol_pos`=1 selects `fb_pulse`. With `cfg_test`=1 and `cfg_tri`=0, the block works normally.
- R7: `cfg_cnt_rst`=1 with `cfg_pwdn`=0 drives `div_hold` to 1 and holds both flags clear, and leaves `pump_oe` at 1.
- R8: `chip_en`=0, or `cfg_pwdn`=1 together with `cfg_cnt_rst`=1, powers the block down in the same cycle, whatever the other inputs (test mode included). The effects are: `pwr_down`=1, `div_hold`=1, `pump_oe`=0, pumps 0, and both flags cleared.
- R9: `cfg_pwdn`=1 with `cfg_cnt_rst`=0 raises `pwr_down` at the first clock edge after which both flags would be clear, so a pulse in progress completes. While powered down, strobes are ignored. Clearing `cfg_pwdn` releases power-down at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Single-cycle strobe from the reference divider |
| fb_pulse | input | 1 | Single-cycle strobe from the feedback divider |
| cfg_pol_pos | input | 1 | 1: positive oscillator slope, 0: negative (up/down swapped) |
| cfg_tri | input | 1 | Force pump to high impedance |
| cfg_test | input | 1 | Route a divider strobe to the pump pins (needs cfg_tri=1) |
| cfg_cnt_rst | input | 1 | Hold the dividers at their load point |
| cfg_pwdn | input | 1 | Power-down request |
| chip_en | input | 1 | Chip enable, low powers down at once |
| pump_up | output | 1 | Drive pump pin towards supply |
| pump_dn | output | 1 | Drive pump pin towards ground |
| pump_oe | output | 1 | Pump output enable, 0 means high impedance |
| pwr_down | output | 1 | Block is powered down |
| div_hold | output | 1 | Dividers must stay at their load point |

## Verification
The assertions assume two things about the inputs. First, the divider strobes are single-cycle pulses synchronous to `clk`. Second, the configuration inputs change only between strobes, so a window that starts in normal mode is not cut short by a mode change. The stimulus changes inputs only once per cycle, one clock unit after the rising edge. It raises each strobe for one cycle only and changes configuration while both flags are clear, or on purpose inside a pulse when cut-off behaviour is the point of the test. The minimum-width and deferred power-down properties are qualified by the mode in force, so they only judge the windows in which those modes hold.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Source of what the pump pins show in a given cycle.
  typedef enum logic [1:0] {
    PUMP_OFF    = 2'd0,
    PUMP_DETECT = 2'd1,
    PUMP_TEST   = 2'd2
  } pump_mode_e;

  // Index of each detector side in the flag vectors.
  localparam int SIDE_REF = 0;
  localparam int SIDE_FB  = 1;
  localparam int N_SIDES  = 2;

endpackage

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int RST_DLY = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SIDES-1:0] set_i,
  input  logic               hold_i,
  output logic [N_SIDES-1:0] flag_o,
  output logic [N_SIDES-1:0] flag_nxt_o
);

  localparam int CW = (RST_DLY > 1) ? $clog2(RST_DLY) : 1;
  localparam logic [CW-1:0] DLY_LAST = CW'(RST_DLY - 1);

  logic [CW-1:0] dly_q;
  logic [CW-1:0] dly_d;
  logic          both_set;
  logic          clr;

  assign both_set = &flag_o;
  assign clr      = both_set && (dly_q == DLY_LAST);

  always_comb begin
    dly_d = dly_q;
    if (hold_i || !both_set || clr) begin
      dly_d = '0;
    end else begin
      dly_d = dly_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
    end else begin
      dly_q <= dly_d;
    end
  end

  // One set/clear flag per side; a new strobe wins over the joint clear.
  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    logic q;
    logic d;

    always_comb begin
      if (hold_i) begin
        d = 1'b0;
      end else begin
        d = set_i[g] | (q & ~clr);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= 1'b0;
      end else begin
        q <= d;
      end
    end

    assign flag_o[g]     = q;
    assign flag_nxt_o[g] = d;
  end

endmodule

// File: rtl/pfd_power_seq.sv
module pfd_power_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en,
  input  logic cfg_pwdn,
  input  logic cfg_cnt_rst,
  input  logic busy_nxt_i,
  output logic pwr_down_o
);

  logic async_pd;
  logic sync_req;
  logic sync_pd_q;
  logic sync_pd_d;

  assign async_pd = ~chip_en | (cfg_pwdn & cfg_cnt_rst);
  assign sync_req = cfg_pwdn & ~cfg_cnt_rst;

  // Enter only on an edge after which no pump pulse would remain.
  always_comb begin
    sync_pd_d = sync_req & (sync_pd_q | ~busy_nxt_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_pd_q <= 1'b0;
    end else begin
      sync_pd_q <= sync_pd_d;
    end
  end

  assign pwr_down_o = async_pd | sync_pd_q;

endmodule

// File: rtl/pfd_pump_mux.sv
module pfd_pump_mux
  import pfd_pkg::*;
(
  input  pump_mode_e         mode_i,
  input  logic               pol_pos_i,
  input  logic [N_SIDES-1:0] flag_i,
  input  logic               ref_i,
  input  logic               fb_i,
  output logic               up_o,
  output logic               dn_o,
  output logic               oe_o
);

  logic test_sel;

  assign test_sel = pol_pos_i ? fb_i : ref_i;

  always_comb begin
    up_o = 1'b0;
    dn_o = 1'b0;
    oe_o = 1'b0;
    case (mode_i)
      PUMP_DETECT: begin
        oe_o = 1'b1;
        up_o = pol_pos_i ? flag_i[SIDE_REF] : flag_i[SIDE_FB];
        dn_o = pol_pos_i ? flag_i[SIDE_FB]  : flag_i[SIDE_REF];
      end
      PUMP_TEST: begin
        oe_o = 1'b1;
        up_o = test_sel;
        dn_o = ~test_sel;
      end
      default: begin
        oe_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pfd_pump_ctrl.sv
module pfd_pump_ctrl
  import pfd_pkg::*;
#(
  parameter int RST_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic fb_pulse,
  input  logic cfg_pol_pos,
  input  logic cfg_tri,
  input  logic cfg_test,
  input  logic cfg_cnt_rst,
  input  logic cfg_pwdn,
  input  logic chip_en,
  output logic pump_up,
  output logic pump_dn,
  output logic pump_oe,
  output logic pwr_down,
  output logic div_hold
);

  logic [N_SIDES-1:0] flag;
  logic [N_SIDES-1:0] flag_nxt;
  logic [N_SIDES-1:0] strobe;
  logic               det_hold;
  logic               pd;
  pump_mode_e         mode;

  assign strobe[SIDE_REF] = ref_pulse;
  assign strobe[SIDE_FB]  = fb_pulse;

  // Comparator is idle whenever the pump cannot show its result.
  assign det_hold = pd | cfg_cnt_rst | cfg_tri;

  always_comb begin
    if (pd) begin
      mode = PUMP_OFF;
    end else if (cfg_tri && cfg_test) begin
      mode = PUMP_TEST;
    end else if (cfg_tri) begin
      mode = PUMP_OFF;
    end else begin
      mode = PUMP_DETECT;
    end
  end

  pfd_core #(.RST_DLY(RST_DLY)) core_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (strobe),
    .hold_i     (det_hold),
    .flag_o     (flag),
    .flag_nxt_o (flag_nxt)
  );

  pfd_power_seq pwr_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_en     (chip_en),
    .cfg_pwdn    (cfg_pwdn),
    .cfg_cnt_rst (cfg_cnt_rst),
    .busy_nxt_i  (|flag_nxt),
    .pwr_down_o  (pd)
  );

  pfd_pump_mux mux_i (
    .mode_i    (mode),
    .pol_pos_i (cfg_pol_pos),
    .flag_i    (flag),
    .ref_i     (ref_pulse),
    .fb_i      (fb_pulse),
    .up_o      (pump_up),
    .dn_o      (pump_dn),
    .oe_o      (pump_oe)
  );

  assign pwr_down = pd;
  assign div_hold = pd | cfg_cnt_rst;

endmodule

// File: rtl/pfd_pump_ctrl_chk.sv
module pfd_pump_ctrl_chk #(
  parameter int RST_DLY = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ref_pulse,
  input logic fb_pulse,
  input logic cfg_pol_pos,
  input logic cfg_tri,
  input logic cfg_test,
  input logic cfg_cnt_rst,
  input logic cfg_pwdn,
  input logic chip_en,
  input logic pump_up,
  input logic pump_dn,
  input logic pump_oe,
  input logic pwr_down,
  input logic div_hold
);

  logic norm;
  logic both;
  logic sync_cfg;

  assign norm     = chip_en && !cfg_tri && !cfg_cnt_rst && !cfg_pwdn;
  assign both     = pump_up && pump_dn;
  assign sync_cfg = cfg_pwdn && !cfg_cnt_rst && !cfg_test;

  p_async_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en || (cfg_pwdn && cfg_cnt_rst)) |->
      (pwr_down && div_hold && !pump_oe && !pump_up && !pump_dn));

  p_tri_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tri && !cfg_test) |-> (!pump_oe && !pump_up && !pump_dn));

  p_test_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tri && cfg_test && !pwr_down) |->
      (pump_oe && (pump_up != pump_dn) &&
       (pump_up == (cfg_pol_pos ? fb_pulse : ref_pulse))));

  p_cnt_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cnt_rst && !cfg_pwdn && chip_en) |-> (div_hold && !pwr_down));

  p_sync_stay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pwdn && !cfg_cnt_rst && $past(cfg_pwdn && !cfg_cnt_rst) && $past(pwr_down))
      |-> pwr_down);

  p_sync_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && sync_cfg && $past(sync_cfg && chip_en) && $rose(pwr_down))
      |-> $past(pump_up == pump_dn));

  if (RST_DLY > 1) begin : g_width
    p_min_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(both) && norm) ##1 norm |-> both);
  end

endmodule

bind pfd_pump_ctrl pfd_pump_ctrl_chk #(.RST_DLY(RST_DLY)) chk_i (.*);

// File: tb/pfd_pump_ctrl_tb_top.sv
module pfd_pump_ctrl_tb_top;

  logic clk;
  logic rst_n;
  logic ref_pulse, fb_pulse, cfg_pol_pos, cfg_tri, cfg_test;
  logic cfg_cnt_rst, cfg_pwdn, chip_en;
  logic pump_up, pump_dn, pump_oe, pwr_down, div_hold;

  int checks = 0;
  int fails  = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  pfd_pump_ctrl #(.RST_DLY(2)) dut_i (.*);

  // {req[3:0], in: ref fb pol tri test crst pwdn ce, exp: up dn oe pd hold}
  localparam logic [16:0] VEC [54] = '{
    {4'd1, 8'b00_100001, 5'b00100},  // 0  R1 idle
    {4'd2, 8'b10_100001, 5'b10100},  // 1  R2 ref leads
    {4'd2, 8'b00_100001, 5'b10100},  // 2
    {4'd3, 8'b01_100001, 5'b11100},  // 3  R3 both set
    {4'd3, 8'b00_100001, 5'b11100},  // 4
    {4'd3, 8'b00_100001, 5'b00100},  // 5  cleared
    {4'd3, 8'b11_100001, 5'b11100},  // 6  R3 locked
    {4'd3, 8'b00_100001, 5'b11100},  // 7
    {4'd3, 8'b00_100001, 5'b00100},  // 8
    {4'd2, 8'b01_100001, 5'b01100},  // 9  R2 fb leads
    {4'd2, 8'b00_100001, 5'b01100},  // 10
    {4'd2, 8'b10_100001, 5'b11100},  // 11
    {4'd3, 8'b00_100001, 5'b11100},  // 12
    {4'd3, 8'b00_100001, 5'b00100},  // 13
    {4'd4, 8'b10_000001, 5'b01100},  // 14 R4 negative slope
    {4'd4, 8'b00_000001, 5'b01100},  // 15
    {4'd4, 8'b01_000001, 5'b11100},  // 16
    {4'd4, 8'b00_000001, 5'b11100},  // 17
    {4'd4, 8'b00_000001, 5'b00100},  // 18
    {4'd5, 8'b10_110001, 5'b00000},  // 19 R5 forced off
    {4'd5, 8'b00_110001, 5'b00000},  // 20
    {4'd6, 8'b10_011001, 5'b10100},  // 21 R6 test, ref selected
    {4'd6, 8'b00_011001, 5'b01100},  // 22
    {4'd6, 8'b01_111001, 5'b10100},  // 23 R6 test, fb selected
    {4'd6, 8'b10_111001, 5'b01100},  // 24
    {4'd6, 8'b10_101001, 5'b10100},  // 25 R6 test without tri
    {4'd6, 8'b00_101001, 5'b10100},  // 26
    {4'd6, 8'b01_101001, 5'b11100},  // 27
    {4'd6, 8'b00_101001, 5'b11100},  // 28
    {4'd5, 8'b00_100001, 5'b00100},  // 29 R5 no leftover pulse
    {4'd7, 8'b10_100101, 5'b00101},  // 30 R7 counter reset
    {4'd7, 8'b00_100001, 5'b00100},  // 31
    {4'd8, 8'b10_100000, 5'b00011},  // 32 R8 chip enable low
    {4'd8, 8'b00_100001, 5'b00100},  // 33
    {4'd8, 8'b00_100111, 5'b00011},  // 34 R8 both bits set
    {4'd8, 8'b00_100001, 5'b00100},  // 35
    {4'd8, 8'b10_100001, 5'b10100},  // 36
    {4'd8, 8'b00_100000, 5'b00011},  // 37 R8 cuts pulse
    {4'd8, 8'b00_100001, 5'b00100},  // 38
    {4'd9, 8'b10_100001, 5'b10100},  // 39 R9 pulse then request
    {4'd9, 8'b00_100011, 5'b10100},  // 40
    {4'd9, 8'b01_100011, 5'b11100},  // 41
    {4'd9, 8'b00_100011, 5'b11100},  // 42
    {4'd9, 8'b00_100011, 5'b00011},  // 43 entered after pulse
    {4'd9, 8'b10_100011, 5'b00011},  // 44 strobe ignored
    {4'd9, 8'b00_100001, 5'b00100},  // 45 released
    {4'd9, 8'b00_100011, 5'b00011},  // 46 idle request
    {4'd9, 8'b00_100001, 5'b00100},  // 47
    {4'd9, 8'b10_100011, 5'b10100},  // 48 strobe with request
    {4'd9, 8'b00_100011, 5'b10100},  // 49
    {4'd9, 8'b01_100011, 5'b11100},  // 50
    {4'd9, 8'b00_100011, 5'b11100},  // 51
    {4'd9, 8'b00_100011, 5'b00011},  // 52
    {4'd9, 8'b00_100001, 5'b00100}   // 53
  };

  task automatic drive(input logic [7:0] in);
    {ref_pulse, fb_pulse, cfg_pol_pos, cfg_tri, cfg_test,
     cfg_cnt_rst, cfg_pwdn, chip_en} = in;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input int req, input int idx, input logic [4:0] exp);
    logic [4:0] act;
    act = {pump_up, pump_dn, pump_oe, pwr_down, div_hold};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d step %0d: actual %b expected %b", req, idx, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {ref_pulse, fb_pulse, cfg_pol_pos, cfg_tri, cfg_test,
     cfg_cnt_rst, cfg_pwdn, chip_en} = 8'b00_100001;
    repeat (3) @(posedge clk);
    #1;
    check(1, -1, 5'b00100);  // R1 in reset
    rst_n = 1'b1;

    for (int i = 0; i < 54; i++) begin
      drive(VEC[i][12:5]);
      check(int'(VEC[i][16:13]), i, VEC[i][4:0]);
    end

    // R2: lead persists over a second reference strobe (range beyond one period)
    drive(8'b10_100001); check(2, 100, 5'b10100);
    drive(8'b00_100001); check(2, 101, 5'b10100);
    drive(8'b10_100001); check(2, 102, 5'b10100);
    drive(8'b00_100001); check(2, 103, 5'b10100);
    drive(8'b01_100001); check(2, 104, 5'b11100);
    drive(8'b00_100001); check(3, 105, 5'b11100);
    drive(8'b00_100001); check(3, 106, 5'b00100);

    // R8: power-down beats test routing
    drive(8'b10_011000); check(8, 110, 5'b00011);
    drive(8'b01_111111); check(8, 111, 5'b00011);
    drive(8'b00_100001); check(8, 112, 5'b00100);

    // R1: reset in the middle of a pulse
    drive(8'b10_100001); check(1, 120, 5'b10100);
    rst_n = 1'b0;
    #1;
    check(1, 121, 5'b00100);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    drive(8'b00_100001); check(1, 122, 5'b00100);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule